// File: doc/BRIEF.md
# Disk Controller Host Register Interface

This block is the host-facing register file of a disk controller that runs chains of command blocks held in memory. The host sees six byte registers. Through them it loads a 16-bit pointer to the first command block and a 16-bit relocation value. It then starts the chain by writing a go bit into an 8-bit control/status register.

The bit reads as busy until the internal sequencer reports that the chain has finished. While the chain runs, the host can raise an attention request. The controller acknowledges the request once the sequencer reports a point where the chain may safely be modified. The sequencer holds off its next block fetch for as long as the acknowledge stays high.

Command completions that ask for an interrupt set a pending flag, and the host clears that flag by writing a one to it. A write to the reset/update register pulses a synchronous reset into the sequencer and clears the live status.

Top module: `dskc_host_regs`

## Requirements
- R1: After reset, all six registers read 0x00 apart from control/status bit 0. `seq_start`, `seq_rst`, `attn_hold` and `irq` are low.
- R2: The 16-bit values are byte-swapped on the bus. Offset 0 holds relocation bits 7:0 and offset 1 holds bits 15:8. Offset 2 holds pointer bits 7:0 and offset 3 holds bits 15:8. Each byte reads back as written and appears on `blk_reloc` and `blk_ptr`.
- R3: The control/status register is at offset 5. Its bits are 7 go/busy, 6 error, 5 double error, 4 interrupt pending, 3 24-bit address mode, 2 attention request, 1 attention acknowledge and 0 drive ready. Bit 3 is read/write and drives `addr24`. Bit 0 mirrors `drive_rdy`.
- R4: Writing 1 to bit 7 while busy is clear sets busy. In the following cycle `seq_start` is high for exactly one cycle.
- R5: Writing 0 to bit 7, or writing 1 to it while busy, has no effect on busy and produces no `seq_start` pulse.
- R6: A `seq_done` pulse clears busy in the next cycle.
- R7: Attention acknowledge (bit 1, also `attn_hold`) rises the cycle after `seq_safe` is seen while the request bit and busy are both set. It stays high while the request bit is set and falls the cycle after the request bit is cleared.
- R8: Error and double error latch `seq_err` and `seq_derr` pulses. Both clear on the next accepted start.
- R9: Interrupt pending is set by a `seq_cmd_irq` pulse and cleared by writing 1 to bit 4. Writing 0 to bit 4 leaves it unchanged. `irq` always equals this bit.
- R10: Any write to offset 4 gives a one-cycle `seq_rst` pulse in the next cycle. The same write clears busy, error, double error, interrupt pending and acknowledge, and leaves the pointer and relocation values unchanged.
- R11: Writes to bits 6, 5, 1 and 0 of the control/status register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Byte register offset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| blk_ptr | output | 16 | First command block pointer |
| blk_reloc | output | 16 | Relocation value |
| addr24 | output | 1 | 24-bit address mode |
| seq_start | output | 1 | One-cycle start pulse to the sequencer |
| seq_rst | output | 1 | One-cycle sequencer reset pulse |
| attn_hold | output | 1 | Attention acknowledged; sequencer must not fetch |
| seq_done | input | 1 | Chain finished pulse |
| seq_cmd_irq | input | 1 | Command with interrupt request completed |
| seq_err | input | 1 | Error pulse |
| seq_derr | input | 1 | Double error pulse |
| seq_safe | input | 1 | Chain may be modified now |
| drive_rdy | input | 1 | Drive ready level |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle:
- an accepted go write is followed by busy and one start pulse;
- no start pulse follows a cycle in which busy was already set;
- acknowledge is low in the cycle after any cycle with the request bit clear;
- a one-to-clear write empties the interrupt flag;
- a reset/update write yields the sequencer reset with busy and interrupt cleared.

Only the bench scenarios can show the behaviours that need a chosen sequence. These are the byte-lane placement of each value, the ignored writes to read-only bits, the error bits surviving until the next accepted start, and the pointer values surviving a reset/update write.

// File: rtl/dskc_host_regs.sv
module dskc_host_regs #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [2*DW-1:0] blk_ptr,
  output logic [2*DW-1:0] blk_reloc,
  output logic          addr24,
  output logic          seq_start,
  output logic          seq_rst,
  output logic          attn_hold,
  input  logic          seq_done,
  input  logic          seq_cmd_irq,
  input  logic          seq_err,
  input  logic          seq_derr,
  input  logic          seq_safe,
  input  logic          drive_rdy,
  output logic          irq
);
  localparam logic [AW-1:0] OFS_RLO = AW'(0);
  localparam logic [AW-1:0] OFS_RHI = AW'(1);
  localparam logic [AW-1:0] OFS_PLO = AW'(2);
  localparam logic [AW-1:0] OFS_PHI = AW'(3);
  localparam logic [AW-1:0] OFS_UPD = AW'(4);
  localparam logic [AW-1:0] OFS_CSR = AW'(5);

  logic [DW-1:0] rlo_q, rhi_q, plo_q, phi_q;
  logic busy_q, err_q, derr_q, ipnd_q, a24_q, areq_q, aack_q;
  logic start_q, rst_q;

  logic csr_wr, upd_wr, go_ok;
  assign csr_wr = bus_wr && (bus_addr == OFS_CSR);
  assign upd_wr = bus_wr && (bus_addr == OFS_UPD);
  assign go_ok  = csr_wr && bus_wdata[7] && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rlo_q <= '0; rhi_q <= '0; plo_q <= '0; phi_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_RLO: rlo_q <= bus_wdata;
        OFS_RHI: rhi_q <= bus_wdata;
        OFS_PLO: plo_q <= bus_wdata;
        OFS_PHI: phi_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; err_q <= 1'b0; derr_q <= 1'b0; ipnd_q <= 1'b0;
      a24_q <= 1'b0; areq_q <= 1'b0; aack_q <= 1'b0;
      start_q <= 1'b0; rst_q <= 1'b0;
    end else begin
      start_q <= go_ok;
      rst_q   <= upd_wr;
      if (csr_wr) begin
        a24_q  <= bus_wdata[3];
        areq_q <= bus_wdata[2];
      end
      if (upd_wr) begin
        busy_q <= 1'b0; err_q <= 1'b0; derr_q <= 1'b0;
        ipnd_q <= 1'b0; aack_q <= 1'b0;
      end else begin
        if (go_ok)         busy_q <= 1'b1;
        else if (seq_done) busy_q <= 1'b0;
        err_q  <= go_ok ? 1'b0 : (err_q  | seq_err);
        derr_q <= go_ok ? 1'b0 : (derr_q | seq_derr);
        if (seq_cmd_irq)                  ipnd_q <= 1'b1;
        else if (csr_wr && bus_wdata[4])  ipnd_q <= 1'b0;
        aack_q <= areq_q && (aack_q || (seq_safe && busy_q));
      end
    end
  end

  logic [DW-1:0] csr;
  assign csr = {busy_q, err_q, derr_q, ipnd_q, a24_q, areq_q, aack_q, drive_rdy};

  always_comb begin
    case (bus_addr)
      OFS_RLO: bus_rdata = rlo_q;
      OFS_RHI: bus_rdata = rhi_q;
      OFS_PLO: bus_rdata = plo_q;
      OFS_PHI: bus_rdata = phi_q;
      OFS_CSR: bus_rdata = csr;
      default: bus_rdata = '0;
    endcase
  end

  assign blk_reloc = {rhi_q, rlo_q};
  assign blk_ptr   = {phi_q, plo_q};
  assign addr24    = a24_q;
  assign seq_start = start_q;
  assign seq_rst   = rst_q;
  assign attn_hold = aack_q;
  assign irq       = ipnd_q;
endmodule

module dskc_host_regs_chk #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic          seq_start,
  input logic          seq_rst,
  input logic          seq_cmd_irq,
  input logic          attn_hold,
  input logic          irq,
  input logic          busy_q,
  input logic          areq_q
);
  a_r4_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(5) && bus_wdata[7] && !busy_q) |=> (seq_start && busy_q));
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) || !seq_start || $past(!busy_q));
  a_r7_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !areq_q |=> !attn_hold);
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(5) && bus_wdata[4] && !seq_cmd_irq) |=> !irq);
  a_r10_upd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(4)) |=> (seq_rst && !busy_q && !irq && !attn_hold));
endmodule

bind dskc_host_regs dskc_host_regs_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/dskc_host_regs_test.sv
module dskc_host_regs_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [15:0] blk_ptr, blk_reloc;
  logic addr24, seq_start, seq_rst, attn_hold, irq;
  logic seq_done = 0, seq_cmd_irq = 0, seq_err = 0, seq_derr = 0, seq_safe = 0, drive_rdy = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dskc_host_regs uut (.*);

  localparam logic [10:0] VEC [4] = '{ {3'd0, 8'h34}, {3'd1, 8'h12}, {3'd2, 8'hCD}, {3'd3, 8'hAB} };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 6; i++) begin rd(i[2:0], v); chk("R1 reg", v, 0); end
    chk("R1 outs", {seq_start, seq_rst, attn_hold, irq}, 0);
    drive_rdy = 1; rd(3'd5, v); chk("R3 drdy mirror", v, 8'h01);
    // R2 table walk
    for (int i = 0; i < 4; i++) begin
      wr(VEC[i][10:8], VEC[i][7:0]);
      rd(VEC[i][10:8], v); chk("R2 readback", v, VEC[i][7:0]);
    end
    chk("R2 reloc lanes", blk_reloc, 16'h1234);
    chk("R2 ptr lanes", blk_ptr, 16'hABCD);
    // R3 addr mode, R11 read-only bits, R5 go=0
    wr(3'd5, 8'h08); rd(3'd5, v); chk("R3 addr24", {7'd0, addr24, v}, 16'h0109);
    wr(3'd5, 8'h6B); rd(3'd5, v); chk("R11 ro bits", v, 8'h09);
    chk("R5 go0 no start", seq_start, 0);
    // R4 start
    wr(3'd5, 8'h88);
    chk("R4 start pulse", seq_start, 1);
    rd(3'd5, v); chk("R4 busy", v, 8'h89);
    @(negedge clk); chk("R4 pulse one cycle", seq_start, 0);
    // R5 go while busy
    wr(3'd5, 8'h88); chk("R5 busy restart", seq_start, 0);
    @(negedge clk); chk("R5 busy restart late", seq_start, 0);
    // R8 errors
    pulse(seq_err); pulse(seq_derr);
    rd(3'd5, v); chk("R8 err latched", v, 8'hE9);
    wr(3'd5, 8'h08); rd(3'd5, v); chk("R11 err not writable", v, 8'hE9);
    // R7 attention
    wr(3'd5, 8'h0C); chk("R7 no ack without safe", attn_hold, 0);
    pulse(seq_safe);
    rd(3'd5, v); chk("R7 ack set", {7'd0, attn_hold, v}, 16'h01EF);
    @(negedge clk); chk("R7 ack held", attn_hold, 1);
    wr(3'd5, 8'h08); chk("R7 ack one cycle more", attn_hold, 1);
    @(negedge clk); chk("R7 ack fell", attn_hold, 0);
    // R6 done
    pulse(seq_done); rd(3'd5, v); chk("R6 busy cleared", v, 8'h69);
    // R8 cleared on accepted start
    wr(3'd5, 8'h88); rd(3'd5, v); chk("R8 err cleared by start", v, 8'h89);
    // R9 interrupt
    pulse(seq_cmd_irq); rd(3'd5, v); chk("R9 ipnd set", {7'd0, irq, v}, 16'h0199);
    wr(3'd5, 8'h08); chk("R9 write0 keeps", irq, 1);
    wr(3'd5, 8'h18); rd(3'd5, v); chk("R9 w1c", {7'd0, irq, v}, 16'h0089);
    // R10 reset/update
    pulse(seq_cmd_irq); pulse(seq_err);
    wr(3'd4, 8'h00);
    chk("R10 seq_rst pulse", seq_rst, 1);
    rd(3'd5, v); chk("R10 status cleared", {7'd0, irq, v}, 16'h0009);
    chk("R10 ptr kept", blk_ptr, 16'hABCD);
    chk("R10 reloc kept", blk_reloc, 16'h1234);
    @(negedge clk); chk("R10 pulse one cycle", seq_rst, 0);
    finish_up();
  end
endmodule